// File: doc/BRIEF.md
# External Interrupt Pending and Mask Unit

This unit is the interrupt front end of a single processor. It keeps two 64-bit registers. The pending register records requests that devices have posted. The enable register records which of those requests software wants to take. Devices post a request with a bus write that carries a source number, so no interrupt wires run to the unit. The interval timer has its own tick input, and that input sets source 0. The unit drives one interrupt line. It also reports the number of the most urgent active source, so a handler can service it, clear it and loop.

Source numbers run opposite to bit significance. Source n lives in register bit 63-n, so source 0 is the most significant bit and has the highest priority. Software reads and writes the registers over a small bus. The bus reads back combinationally and writes at the clock edge. Pending bits are cleared by writing ones. A mode input narrows the accepted source range from 64 to 32. A posting write that cannot be accepted is dropped and recorded in a sticky error flag.

Top module: `eirUnit`

## Requirements
- R1: Reset (rstN low) clears the pending register, the enable register and the error flag. While reset is held, irqOut is 0 and irqNum is 0.
- R2: A posting write (postValid high) carrying an accepted number n sets pending bit 63-n at the next clock edge. An accepted number is nonzero and inside the active range.
- R3: A register write to address 0 clears each pending bit whose position is 1 in regWdata. Pending bits whose data bit is 0 keep their value.
- R4: A write to address 1 loads the enable register, and address 1 reads it back. irqOut is the OR of (pending AND enable). An all-zero enable value forces irqOut low and keeps every pending bit.
- R5: irqNum is the lowest source number whose pending and enable bits are both 1. When no source is active, irqNum is 0 and irqOut is 0.
- R6: With wideMode low, only numbers 1 to 31 are accepted. A posting write with a number of 32 or more leaves the pending register unchanged and sets postErr. postErr stays at 1 until reset.
- R7: Source 0 belongs to the timer. A posting write of number 0 is dropped and sets postErr. A timerTick pulse sets pending bit 63.
- R8: If a posting write and a clearing write hit the same pending bit in one cycle, the bit ends up set.
- R9: Reads are combinational. Address 0 returns the raw pending value, and address 2 returns pending AND enable. Address 3 returns status: irqOut in bit 0, postErr in bit 1, irqNum in bits 13:8, and zero in all other bits. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | 1: sources 0-63 accepted, 0: sources 0-31 |
| postValid | input | 1 | A posting write is present this cycle |
| postNum | input | 6 | Source number carried by the posting write |
| timerTick | input | 1 | Interval timer request (source 0) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 pending, 1 enable, 2 active, 3 status |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data, combinational from regAddr |
| irqOut | output | 1 | Any pending and enabled source |
| irqNum | output | 6 | Lowest active source number |
| postErr | output | 1 | Sticky flag for dropped posting writes |

## Verification
Every state change lands at the clock edge that samples the write, post or tick. Register reads, irqOut and irqNum then follow combinationally, so each result is due in the half cycle after that edge. The bench drives every input at the falling edge and holds it through one rising edge. It then checks at the next falling edge, one register stage after the stimulus. Read checks apply the address at a falling edge and sample a nanosecond later, before any further edge can alter state.

// File: rtl/eirPkg.sv
package eirPkg;
  parameter int EIR_W = 64;
  parameter int NUM_W = $clog2(EIR_W);
  parameter int NARROW_SRC = 32;
  parameter int ADDR_W = 2;
  parameter int PRIO_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PEND   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_ACTIVE = 2'd2,
    SEL_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             clrPend;
    logic             loadEnable;
    logic             setPost;
    logic [NUM_W-1:0] postIdx;
    logic             setTimer;
    logic             raiseErr;
    regSel_e          readSel;
  } eirStrobe_t;
endpackage

// File: rtl/eirPrioEnc.sv
module eirPrioEnc #(
  parameter int W  = 64,
  parameter int NW = $clog2(W)
) (
  input  logic [W-1:0]  activeVec,
  output logic          anyActive,
  output logic [NW-1:0] lowestNum
);
  // Source n sits in bit W-1-n; scanning numbers from high to low lets
  // the lowest active number overwrite the result last.
  always_comb begin
    lowestNum = '0;
    for (int n = W - 1; n >= 0; n--) begin
      if (activeVec[W-1-n]) lowestNum = NW'(n);
    end
  end

  assign anyActive = |activeVec;
endmodule

// File: rtl/eirCtrl.sv
module eirCtrl
  import eirPkg::*;
(
  input  logic              wideMode,
  input  logic              postValid,
  input  logic [NUM_W-1:0]  postNum,
  input  logic              timerTick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output eirStrobe_t        strobe
);
  localparam logic [NUM_W:0] WIDE_LIMIT   = (NUM_W+1)'(EIR_W);
  localparam logic [NUM_W:0] NARROW_LIMIT = (NUM_W+1)'(NARROW_SRC);

  logic [NUM_W:0] srcLimit;
  logic           numInRange;
  logic           numAccepted;

  assign srcLimit    = wideMode ? WIDE_LIMIT : NARROW_LIMIT;
  assign numInRange  = {1'b0, postNum} < srcLimit;
  // Source 0 is owned by the timer and never accepted from the bus.
  assign numAccepted = numInRange && (postNum != '0);

  always_comb begin
    strobe            = '0;
    strobe.readSel    = regSel_e'(regAddr);
    strobe.clrPend    = regWe && (regSel_e'(regAddr) == SEL_PEND);
    strobe.loadEnable = regWe && (regSel_e'(regAddr) == SEL_ENABLE);
    strobe.setPost    = postValid && numAccepted;
    strobe.postIdx    = postNum;
    strobe.setTimer   = timerTick;
    strobe.raiseErr   = postValid && !numAccepted;
  end
endmodule

// File: rtl/eirDatapath.sv
module eirDatapath
  import eirPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  eirStrobe_t       strobe,
  input  logic [EIR_W-1:0] wrData,
  output logic [EIR_W-1:0] pendQ,
  output logic [EIR_W-1:0] enableQ,
  output logic             errQ,
  output logic [EIR_W-1:0] rdData,
  output logic             irqLine,
  output logic [NUM_W-1:0] irqSrc
);
  logic [EIR_W-1:0] setVec;
  logic [EIR_W-1:0] clrVec;
  logic [EIR_W-1:0] activeVec;
  logic [EIR_W-1:0] statusWord;
  logic             anyActive;
  logic [NUM_W-1:0] lowestNum;

  always_comb begin
    setVec = '0;
    if (strobe.setPost)  setVec[(EIR_W-1) - int'(strobe.postIdx)] = 1'b1;
    if (strobe.setTimer) setVec[EIR_W-1] = 1'b1;
  end

  assign clrVec = strobe.clrPend ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      enableQ <= '0;
      errQ    <= 1'b0;
    end else begin
      // Set after clear: a fresh request beats a same-cycle clear.
      pendQ <= (pendQ & ~clrVec) | setVec;
      if (strobe.loadEnable) enableQ <= wrData;
      if (strobe.raiseErr)   errQ    <= 1'b1;
    end
  end

  assign activeVec = pendQ & enableQ;

  eirPrioEnc #(.W(EIR_W), .NW(NUM_W)) prioEnc (
    .activeVec (activeVec),
    .anyActive (anyActive),
    .lowestNum (lowestNum)
  );

  assign irqLine = anyActive;
  assign irqSrc  = lowestNum;

  always_comb begin
    statusWord = '0;
    statusWord[0] = anyActive;
    statusWord[1] = errQ;
    statusWord[PRIO_LSB +: NUM_W] = lowestNum;
  end

  always_comb begin
    unique case (strobe.readSel)
      SEL_PEND:   rdData = pendQ;
      SEL_ENABLE: rdData = enableQ;
      SEL_ACTIVE: rdData = activeVec;
      default:    rdData = statusWord;
    endcase
  end
endmodule

// File: rtl/eirUnit.sv
module eirUnit
  import eirPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideMode,
  input  logic              postValid,
  input  logic [NUM_W-1:0]  postNum,
  input  logic              timerTick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EIR_W-1:0]  regWdata,
  output logic [EIR_W-1:0]  regRdata,
  output logic              irqOut,
  output logic [NUM_W-1:0]  irqNum,
  output logic              postErr
);
  eirStrobe_t       strobe;
  logic [EIR_W-1:0] pendQ;
  logic [EIR_W-1:0] enableQ;

  eirCtrl ctrl (
    .wideMode  (wideMode),
    .postValid (postValid),
    .postNum   (postNum),
    .timerTick (timerTick),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .strobe    (strobe)
  );

  eirDatapath dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWdata),
    .pendQ   (pendQ),
    .enableQ (enableQ),
    .errQ    (postErr),
    .rdData  (regRdata),
    .irqLine (irqOut),
    .irqSrc  (irqNum)
  );
endmodule

// File: rtl/eirChecker.sv
module eirChecker
  import eirPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wideMode,
  input logic              postValid,
  input logic [NUM_W-1:0]  postNum,
  input logic              timerTick,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [EIR_W-1:0]  regWdata,
  input logic              irqOut,
  input logic [NUM_W-1:0]  irqNum,
  input logic              postErr,
  input logic [EIR_W-1:0]  pendQ,
  input logic [EIR_W-1:0]  enableQ
);
  logic [NUM_W-1:0] numQ;
  logic             goodPost;

  assign goodPost = postValid && (postNum != '0) && (wideMode || (int'(postNum) < NARROW_SRC));

  always_ff @(posedge clk) numQ <= postNum;

  // R1: the cycle after reset is sampled, all state is clear.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (pendQ == '0) && (enableQ == '0) && !postErr);

  // R2, R8: an accepted post always leaves its bit set, clear or no clear.
  assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    goodPost |=> pendQ[(EIR_W-1) - int'(numQ)]);

  // R3: a full clear with no new request empties the register.
  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd0 && regWdata == '1 && !postValid && !timerTick) |=> (pendQ == '0));

  // R4: a zeroed enable register silences the line.
  assert_zero_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1 && regWdata == '0) |=> !irqOut);

  // R5: the reported source is both pending and enabled.
  assert_prio_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendQ[(EIR_W-1) - int'(irqNum)] && enableQ[(EIR_W-1) - int'(irqNum)]));

  // R6: an out-of-range narrow post raises the error flag.
  assert_narrow_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && !wideMode && int'(postNum) >= NARROW_SRC) |=> postErr);

  // R6: the error flag is sticky.
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    postErr |=> postErr);

  // R7: the timer tick sets source 0.
  assert_timer_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |=> pendQ[EIR_W-1]);
endmodule

bind eirUnit eirChecker chk (
  .clk       (clk),
  .rstN      (rstN),
  .wideMode  (wideMode),
  .postValid (postValid),
  .postNum   (postNum),
  .timerTick (timerTick),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .irqOut    (irqOut),
  .irqNum    (irqNum),
  .postErr   (postErr),
  .pendQ     (pendQ),
  .enableQ   (enableQ)
);

// File: tb/eirUnit_test.sv
module eirUnit_test;
  localparam int W = 64;
  localparam int HALF = 4;
  localparam logic [1:0] OP_POST = 2'd0, OP_WPEND = 2'd1, OP_WMASK = 2'd2, OP_READ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  num;
    logic [1:0]  addr;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] B5  = 64'd1 << 58;
  localparam logic [63:0] B40 = 64'd1 << 23;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{OP_READ,  6'd0,  2'd0, 64'd0,                 8'd1}, // R1 pending clear
    '{OP_READ,  6'd0,  2'd1, 64'd0,                 8'd1}, // R1 enable clear
    '{OP_POST,  6'd5,  2'd0, 64'd0,                 8'd2}, // R2
    '{OP_POST,  6'd40, 2'd0, 64'd0,                 8'd2}, // R2
    '{OP_READ,  6'd0,  2'd0, B5 | B40,              8'd2}, // R2 bits 58 and 23
    '{OP_READ,  6'd0,  2'd3, 64'd0,                 8'd4}, // R4 mask zero, no irq
    '{OP_WMASK, 6'd0,  2'd1, '1,                    8'd4}, // R4
    '{OP_READ,  6'd0,  2'd3, (64'd5 << 8) | 64'd1,  8'd5}, // R5 source 5 wins
    '{OP_READ,  6'd0,  2'd2, B5 | B40,              8'd9}, // R9 masked view
    '{OP_WPEND, 6'd0,  2'd0, B5,                    8'd3}, // R3 clear source 5
    '{OP_READ,  6'd0,  2'd3, (64'd40 << 8) | 64'd1, 8'd5}, // R5 source 40 now
    '{OP_WMASK, 6'd0,  2'd1, B5,                    8'd4}, // R4
    '{OP_READ,  6'd0,  2'd3, 64'd0,                 8'd4}, // R4 masked off
    '{OP_READ,  6'd0,  2'd0, B40,                   8'd4}, // R4 pending kept
    '{OP_READ,  6'd0,  2'd2, 64'd0,                 8'd9}, // R9
    '{OP_WPEND, 6'd0,  2'd0, '1,                    8'd3}, // R3 clear all
    '{OP_READ,  6'd0,  2'd0, 64'd0,                 8'd3}  // R3
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wideMode = 1'b1;
  logic        postValid = 1'b0;
  logic [5:0]  postNum = '0;
  logic        timerTick = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        irqOut;
  logic [5:0]  irqNum;
  logic        postErr;

  int checks = 0;
  int fails = 0;

  always #HALF clk = ~clk;

  eirUnit uut (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .postValid(postValid),
    .postNum(postNum), .timerTick(timerTick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .irqNum(irqNum),
    .postErr(postErr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge, take effect at the next rising edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    postValid = 1'b0; regWe = 1'b0; timerTick = 1'b0;
  endtask

  task automatic post(input logic [5:0] n);
    postValid = 1'b1; postNum = n; cycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d; cycle();
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [63:0] exp);
    regAddr = a; #1;
    check(tag, regRdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 irqOut in reset", {63'd0, irqOut}, 64'd0);
    check("R1 irqNum in reset", {58'd0, irqNum}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_POST:  post(VECS[i].num);
        OP_WPEND: wr(2'd0, VECS[i].data);
        OP_WMASK: wr(2'd1, VECS[i].data);
        default:  rd($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
      endcase
    end

    // R8: post and clear of the same bit in one cycle
    wr(2'd1, '1);
    post(6'd7);
    postValid = 1'b1; postNum = 6'd7; regWe = 1'b1; regAddr = 2'd0; regWdata = 64'd1 << 56;
    cycle();
    rd("R8 post beats clear", 2'd0, 64'd1 << 56);
    check("R8 irqNum", {58'd0, irqNum}, 64'd7);

    // R7: timer tick and reserved number 0
    check("R7 no error yet", {63'd0, postErr}, 64'd0);
    post(6'd0);
    rd("R7 post of 0 dropped", 2'd0, 64'd1 << 56);
    check("R7 post of 0 flags", {63'd0, postErr}, 64'd1);
    timerTick = 1'b1; cycle();
    rd("R7 timer sets bit 63", 2'd0, (64'd1 << 63) | (64'd1 << 56));
    check("R7 timer top priority", {58'd0, irqNum}, 64'd0);
    check("R7 irq with timer", {63'd0, irqOut}, 64'd1);

    // R1: reset mid-run
    rstN = 1'b0; cycle(); rstN = 1'b1;
    rd("R1 pending after reset", 2'd0, 64'd0);
    rd("R1 enable after reset", 2'd1, 64'd0);
    check("R1 error after reset", {63'd0, postErr}, 64'd0);

    // R6: narrow mode
    wideMode = 1'b0;
    post(6'd40);
    rd("R6 narrow drops 40", 2'd0, 64'd0);
    check("R6 narrow flags 40", {63'd0, postErr}, 64'd1);
    post(6'd31);
    rd("R6 narrow accepts 31", 2'd0, 64'd1 << 32);
    check("R6 error sticky", {63'd0, postErr}, 64'd1);
    wideMode = 1'b1;
    post(6'd63);
    rd("R2 wide accepts 63", 2'd0, (64'd1 << 32) | 64'd1);

    // R9: writes to active and status addresses change nothing
    wr(2'd1, 64'd1);
    wr(2'd2, '1);
    wr(2'd3, '1);
    rd("R9 pending untouched", 2'd0, (64'd1 << 32) | 64'd1);
    rd("R9 enable untouched", 2'd1, 64'd1);
    rd("R9 status layout", 2'd3, (64'd63 << 8) | 64'd3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 5000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule